// File: doc/BRIEF.md
# Multicast Address Overlay Rewriter

This block is a per-port egress stage for multicast requests that have already been accepted by the port. It takes a request header that carries a 64-bit address and a flag for the header format: 3 doublewords or 4 doublewords. It returns the rewritten address together with the header format that suits the new address. Each port instance keeps its own overlay base address and its own overlay size. The rewrite is the same whichever direction the port faces.

While the size is zero, the rewrite is off and the header goes through untouched. When the size is nonzero, every address bit at or above that bit position is taken from the overlay base. Every bit below that position stays as it came in. The rewrite can move an address across the 4 GB line in either direction. The header format then follows the result: an address whose upper half is zero uses 3 doublewords, and any other address uses 4. The result is registered. It uses a valid/ready handshake and can take a new header on every cycle.

Top module: `mcast_overlay_rewriter`

## Requirements
- R1: After reset, outValid is 0, inReady is 1, and the base and size are zero, so the first headers pass through unchanged.
- R2: While the size is 0, outAddr equals inAddr with bits 1:0 cleared, and outFourDw equals inFourDw.
- R3: While the size is nonzero, each outAddr bit at a position greater than or equal to the size comes from the same bit of the overlay base.
- R4: While the size is nonzero, each outAddr bit at a position below the size, other than bits 1:0, comes from the same bit of inAddr. Base bits below the size have no effect.
- R5: A configuration write with cfgWrEn=1 acts by cfgSel. Code 0 loads base[31:0] from cfgWrData. Code 1 loads base[63:32]. Code 2 loads the size from cfgWrData[5:0], and the other data bits are ignored. Code 3 changes nothing.
- R6: While the size is nonzero, outFourDw is 0 when outAddr[63:32] is all zero and 1 otherwise. This can shrink a 4-doubleword header to 3 or grow a 3-doubleword header to 4.
- R7: outAddr[1:0] is always 0 while outValid is 1.
- R8: A header accepted at a clock edge (inValid and inReady both 1) shows up with outValid=1 right after that edge. The configuration it uses is the one in force at that edge.
- R9: While outValid=1 and outReady=0, inReady is 0, and outAddr and outFourDw hold steady into the next cycle.
- R10: While outReady=1, inReady is 1, so one header per cycle is sustained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration target: 0 base low, 1 base high, 2 size |
| cfgWrData | input | 32 | Configuration write data |
| inValid | input | 1 | Input header valid |
| inReady | output | 1 | Block can take a header this cycle |
| inAddr | input | 64 | Input request address |
| inFourDw | input | 1 | Input header is in 4-doubleword form |
| outValid | output | 1 | Output header valid |
| outReady | input | 1 | Downstream takes the output this cycle |
| outAddr | output | 64 | Rewritten address |
| outFourDw | output | 1 | Output header is in 4-doubleword form |

## Verification
The bench goes after the two format flips. A header with an upper address above 4 GB can land below it and must shrink, and a low address given a nonzero upper base must grow. A design that copied the input format would emit a header of the wrong length for its address. It also runs the extreme sizes 2 and 63 and a size write with junk in the upper data bits. An off-by-one in the mask there would take one bit too many or too few from the base, and a wide size decode would pick up a wrong size. Random backpressure checks that a stalled output never changes and that no header is dropped or doubled. Each header is rewritten with the configuration in force when it was accepted.

// File: rtl/mcast_overlay_pkg.sv
package mcast_overlay_pkg;

  typedef enum logic [1:0] {
    SEL_BASE_LO = 2'd0,
    SEL_BASE_HI = 2'd1,
    SEL_SIZE    = 2'd2,
    SEL_NONE    = 2'd3
  } cfgSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadOut;
    logic wrBaseLo;
    logic wrBaseHi;
    logic wrSize;
  } ovlStrobe_t;

endpackage

// File: rtl/mcast_overlay_ctrl.sv
module mcast_overlay_ctrl
  import mcast_overlay_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgSel,
  input  logic       inValid,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output ovlStrobe_t strobe
);

  logic validQ;

  // The output slot is free when it is empty or being drained
  assign inReady  = !validQ || outReady;
  assign outValid = validQ;

  always_comb begin
    strobe          = '0;
    strobe.loadOut  = inValid && inReady;
    strobe.wrBaseLo = cfgWrEn && (cfgSel == SEL_BASE_LO);
    strobe.wrBaseHi = cfgWrEn && (cfgSel == SEL_BASE_HI);
    strobe.wrSize   = cfgWrEn && (cfgSel == SEL_SIZE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (inReady) begin
      validQ <= inValid;
    end
  end

endmodule

// File: rtl/mcast_overlay_dpath.sv
module mcast_overlay_dpath
  import mcast_overlay_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int SIZE_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  ovlStrobe_t          strobe,
  input  logic [ADDR_W/2-1:0] cfgWrData,
  input  logic [ADDR_W-1:0]   inAddr,
  input  logic                inFourDw,
  output logic [ADDR_W-1:0]   outAddr,
  output logic                outFourDw,
  output logic                outRewritten
);

  localparam int HALF_W = ADDR_W / 2;

  logic [ADDR_W-1:0] baseQ;
  logic [SIZE_W-1:0] sizeQ;
  logic [ADDR_W-1:0] keepMask;
  logic [ADDR_W-1:0] mixedAddr;
  logic [ADDR_W-1:0] nextAddr;
  logic              nextFourDw;
  logic              overlayOn;

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      sizeQ <= '0;
    end else begin
      if (strobe.wrBaseLo) baseQ[HALF_W-1:0]      <= cfgWrData;
      if (strobe.wrBaseHi) baseQ[ADDR_W-1:HALF_W] <= cfgWrData;
      if (strobe.wrSize)   sizeQ                  <= cfgWrData[SIZE_W-1:0];
    end
  end

  // One mask bit per address bit: keep the input bit below the size
  for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
    assign keepMask[i] = (32'(sizeQ) > i);
  end

  assign overlayOn = (sizeQ != '0);
  assign mixedAddr = (inAddr & keepMask) | (baseQ & ~keepMask);

  always_comb begin
    if (overlayOn) begin
      nextAddr   = {mixedAddr[ADDR_W-1:2], 2'b00};
      nextFourDw = |nextAddr[ADDR_W-1:HALF_W];
    end else begin
      nextAddr   = {inAddr[ADDR_W-1:2], 2'b00};
      nextFourDw = inFourDw;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outAddr      <= '0;
      outFourDw    <= 1'b0;
      outRewritten <= 1'b0;
    end else if (strobe.loadOut) begin
      outAddr      <= nextAddr;
      outFourDw    <= nextFourDw;
      outRewritten <= overlayOn;
    end
  end

endmodule

// File: rtl/mcast_overlay_rewriter.sv
module mcast_overlay_rewriter
  import mcast_overlay_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int SIZE_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [1:0]          cfgSel,
  input  logic [ADDR_W/2-1:0] cfgWrData,
  input  logic                inValid,
  output logic                inReady,
  input  logic [ADDR_W-1:0]   inAddr,
  input  logic                inFourDw,
  output logic                outValid,
  input  logic                outReady,
  output logic [ADDR_W-1:0]   outAddr,
  output logic                outFourDw
);

  ovlStrobe_t strobe;
  logic       outRewritten;

  mcast_overlay_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgSel   (cfgSel),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  mcast_overlay_dpath #(
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cfgWrData    (cfgWrData),
    .inAddr       (inAddr),
    .inFourDw     (inFourDw),
    .outAddr      (outAddr),
    .outFourDw    (outFourDw),
    .outRewritten (outRewritten)
  );

endmodule

// File: rtl/mcast_overlay_chk.sv
module mcast_overlay_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [ADDR_W-1:0] outAddr,
  input logic              outFourDw,
  input logic              outRewritten
);

  localparam int HALF_W = ADDR_W / 2;

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outAddr) && $stable(outFourDw));

  // R9
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !inReady);

  // R10
  full_rate_chk: assert property (@(posedge clk) disable iff (!rstN)
    outReady |-> inReady);

  // R8
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> outValid);

  // R7
  low_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outAddr[1:0] == 2'b00);

  // R6
  format_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outRewritten |-> outFourDw == (outAddr[ADDR_W-1:HALF_W] != '0));

endmodule

bind mcast_overlay_rewriter mcast_overlay_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .inValid      (inValid),
  .inReady      (inReady),
  .outValid     (outValid),
  .outReady     (outReady),
  .outAddr      (outAddr),
  .outFourDw    (outFourDw),
  .outRewritten (outRewritten)
);

// File: tb/test_mcast_overlay_rewriter.sv
module test_mcast_overlay_rewriter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgSel = 2'd0;
  logic [31:0] cfgWrData = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [63:0] inAddr = '0;
  logic        inFourDw = 1'b0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [63:0] outAddr;
  logic        outFourDw;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [63:0] mBase = '0;
  logic [5:0]  mSize = '0;
  logic [64:0] expQ[$];
  logic        holdPrev = 0;
  logic [64:0] prevOut = '0;
  logic        latPending = 0;

  always #5 clk = ~clk;

  mcast_overlay_rewriter i_mcast_overlay_rewriter (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgWrData(cfgWrData),
    .inValid(inValid), .inReady(inReady), .inAddr(inAddr), .inFourDw(inFourDw),
    .outValid(outValid), .outReady(outReady), .outAddr(outAddr), .outFourDw(outFourDw)
  );

  function automatic logic [64:0] refModel(logic [63:0] a, logic four);
    logic [63:0] keep;
    logic [63:0] r;
    if (mSize == 0) begin
      r = a & ~64'h3;
      return {four, r};
    end
    keep = (64'd1 << mSize) - 64'd1;
    r = ((a & keep) | (mBase & ~keep)) & ~64'h3;
    return {(r[63:32] != 32'd0), r};
  endfunction

  task automatic check(bit ok, string tag, logic [64:0] act, logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, logic [63:0] a, bit four, bit rdy);
    logic [64:0] e;
    @(negedge clk);
    inValid = v; inAddr = a; inFourDw = four; outReady = rdy;
    #1;
    if (latPending) check(outValid == 1'b1, "R8 latency", {64'd0, outValid}, 65'd1);
    latPending = 0;
    if (holdPrev) check({outFourDw, outAddr} == prevOut, "R9 hold", {outFourDw, outAddr}, prevOut);
    if (outReady) check(inReady == 1'b1, "R10 full rate", {64'd0, inReady}, 65'd1);
    if (outValid && !outReady) check(inReady == 1'b0, "R9 stall ready", {64'd0, inReady}, 65'd0);
    holdPrev = outValid && !outReady;
    prevOut = {outFourDw, outAddr};
    if (outValid && outReady) begin
      if (expQ.size() == 0) begin
        check(0, "R8 spurious output", {outFourDw, outAddr}, 65'd0);
      end else begin
        e = expQ.pop_front();
        check(outAddr == e[63:0], "R2 R3 R4 R7 address", {1'b0, outAddr}, {1'b0, e[63:0]});
        check(outFourDw == e[64], "R6 format", {64'd0, outFourDw}, {64'd0, e[64]});
      end
    end
    if (inValid && inReady) begin
      expQ.push_back(refModel(a, four));
      latPending = 1;
    end
  endtask

  task automatic cfgWrite(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    inValid = 0; cfgWrEn = 1; cfgSel = sel; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 0;
    // R5 model
    case (sel)
      2'd0: mBase[31:0] = d;
      2'd1: mBase[63:32] = d;
      2'd2: mSize = d[5:0];
      default: ;
    endcase
  endtask

  task automatic drain();
    for (int k = 0; k < 4; k++) step(0, 64'd0, 0, 1);
    check(expQ.size() == 0, "R8 drained", 65'(expQ.size()), 65'd0);
  endtask

  task automatic randomRun(int n);
    for (int k = 0; k < n; k++) begin
      logic [63:0] a;
      a = {$urandom, $urandom};
      if ($urandom_range(0, 3) == 0) a[63:32] = 32'd0;
      step($urandom_range(0, 3) != 0, a, a[63:32] != 0, $urandom_range(0, 3) != 0);
    end
    drain();
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    check(outValid == 1'b0, "R1 outValid", {64'd0, outValid}, 65'd0);
    check(inReady == 1'b1, "R1 inReady", {64'd0, inReady}, 65'd1);

    // R1 R2 passthrough with reset config, low bits cleared (R7)
    step(1, 64'h1234_5678_9ABC_DEF3, 1, 1);
    step(1, 64'h0000_0000_0000_00FF, 1, 1);
    drain();
    randomRun(200);

    // R6 shrink: upper base zero, size 24, high input address
    cfgWrite(2'd0, 32'hC000_0000);
    cfgWrite(2'd1, 32'h0);
    cfgWrite(2'd2, 32'd24);
    step(1, 64'hFFFF_0001_00AB_CDEF, 1, 1);
    drain();
    randomRun(300);

    // R6 grow: nonzero upper base, size 20, low input address
    cfgWrite(2'd1, 32'h0000_0005);
    cfgWrite(2'd2, 32'd20);
    step(1, 64'h0000_0000_1234_5678, 0, 1);
    drain();
    randomRun(300);

    // R3 R4 extremes: size 63 and size 2 (written with junk upper bits, R5)
    cfgWrite(2'd0, 32'hFFFF_FFFF);
    cfgWrite(2'd1, 32'h8000_0000);
    cfgWrite(2'd2, 32'hFFFF_FFFF);
    step(1, 64'h7FFF_FFFF_FFFF_FFFF, 1, 1);
    step(1, 64'h0, 0, 1);
    drain();
    cfgWrite(2'd2, 32'hFFFF_FFC2);
    step(1, 64'h0123_4567_89AB_CDEF, 0, 1);
    drain();
    randomRun(300);

    // R5 code 3 changes nothing
    cfgWrite(2'd3, 32'h0000_001F);
    randomRun(200);

    // R2 back to passthrough
    cfgWrite(2'd2, 32'h0000_0040);
    randomRun(300);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule